// File: doc/BRIEF.md
# Flash Program and Erase Status Engine

This block follows one embedded program or erase operation on a small sectored flash array and decides what a read returns while that operation runs. Commands arrive already decoded, one per cycle, together with an address and a data byte. A four-entry protect vector marks sectors that may not be changed. While an operation is active, every read returns a status byte instead of array contents. The status byte carries a polling bit, a toggle bit, an error bit and an erase-window bit. When the engine is idle, reads return the stored byte.

Sector erase requests are gathered into one batch. Each request opens or reopens a timed window, and the batch starts when the window closes. The erase runs in two phases. First every selected sector is filled with 00h, then it is filled with FFh. A sector erase can be suspended so that other sectors can be read, and then either resumed or abandoned. A fault input stands in for a cell failure and latches the error report. Every duration is a clock-count parameter. The top two address bits select one of four sectors.

Top module: `fse_engine`

## Requirements
- R1: After reset every array byte is FFh, the engine is idle and `rd_data` is 00h until the first read.
- R2: A read sampled on a clock edge with `rd_en` high shows its result on `rd_data` after that edge. The status byte has bit7 = poll, bit6 = toggle, bit5 = error and bit3 = window done, and every other bit reads 0. The program command is `cmd_op` 0. During a program the status byte has bit7 equal to the inverse of bit7 of the data being written, and bit5 and bit3 clear. PROG_CYC cycles after the command the byte holds the old value ANDed with the data, and reads return it.
- R3: During the erase window and during both erase phases, status bit7 reads 0. When the erase completes, every byte of each erased sector reads FFh.
- R4: The toggle bit starts at 0 after reset and inverts after every read that returns a status byte. This includes reads in the failed state. It does not change on other reads.
- R5: A high `fault` during a program or an erase phase moves the engine to a failed state. In that state reads return a status byte with bit5 = 1 and the write is not done. Only reset (`cmd_op` 5) leaves this state, and afterwards reads return array data.
- R6: Sector erase is `cmd_op` 1. During its window, status bit3 reads 0. During the fill-00h and fill-FFh phases it reads 1.
- R7: A sector erase command received inside the window adds its sector to the batch and restarts a full WIN_CYC window from that command.
- R8: A program to a protected sector is ignored. If every sector in a batch is protected when the window closes, reads return 00h for PROT_CYC cycles and nothing changes. Bulk erase is `cmd_op` 2. With all sectors protected it is ignored. Otherwise it erases only the unprotected sectors.
- R9: Suspend is `cmd_op` 3 and is accepted during a sector erase window or erase phase. While suspended, reads of a sector in the batch return BAD_BYTE (default C3h), and reads of any other sector return its stored byte.
- R10: While suspended, only resume (`cmd_op` 4) and reset have an effect. Resume continues the erase to completion. Reset abandons it and leaves the array unchanged by the erase.
- R11: Inside the window, any command other than sector erase, suspend or resume abandons the batch without erasing and is not executed. Suspend during a bulk erase is ignored.
- R12: The engine ignores commands during a program. Reset during the fill-FFh phase leaves the batch sectors reading 00h, because the fill-00h phase has already completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code: 0 program, 1 sector erase, 2 bulk erase, 3 suspend, 4 resume, 5 reset |
| cmd_addr | input | ADDR_W | Command address; the top two bits select the sector |
| cmd_data | input | 8 | Program data |
| sect_prot | input | 4 | Per-sector protect flags, bit n for sector n |
| fault | input | 1 | Injected failure during a program or erase phase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: status byte or array byte |

## Verification
The hardest states to reach from the ports are a window restarted by a late second request and a fill-FFh phase that is interrupted. Both depend on where a command lands relative to internal counters that cannot be seen from outside. The bench counts every edge its tasks consume, so it can place a read just after the point where the first window would have closed, and place a reset after the fill-00h phase but before the fill-FFh phase ends. Suspend, fault and all-protected cases are driven the same way. The directed cases are followed by seeded random programs under random protect masks, checked against an array model kept in the bench.

// File: rtl/fse_pkg.sv
package fse_pkg;

    localparam int NSECT = 4;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PROG, PH_WIN, PH_PROTW, PH_PRE, PH_ERASE, PH_SUSP, PH_FAIL
    } phase_e;

    typedef enum logic [2:0] {
        OP_PROGRAM = 3'd0, OP_SECT_ERASE = 3'd1, OP_BULK_ERASE = 3'd2,
        OP_SUSPEND = 3'd3, OP_RESUME = 3'd4, OP_RESET = 3'd5
    } op_e;

    typedef struct packed {
        logic       poll;
        logic       tog;
        logic       err;
        logic       rsv4;
        logic       win_done;
        logic [2:0] rsv;
    } status_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_status_phase(input phase_e p);
        return (p == PH_PROG) || (p == PH_WIN) || (p == PH_PRE) ||
               (p == PH_ERASE) || (p == PH_FAIL);
    endfunction

endpackage

// File: rtl/fse_array.sv
module fse_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              fill_en,
    input  logic [3:0]        fill_mask,
    input  logic [7:0]        fill_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_word
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SECT_SIZE = DEPTH / fse_pkg::NSECT;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int SEC = g / SECT_SIZE;
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= 8'hFF;
            end else if (fill_en && fill_mask[SEC]) begin
                cell_q <= fill_val;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                cell_q <= cell_q & wr_data;
            end
        end
        assign cells[g] = cell_q;
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/fse_seq.sv
module fse_seq
    import fse_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PROG_CYC  = 6,
    parameter int WIN_CYC   = 16,
    parameter int PRE_CYC   = 5,
    parameter int ERASE_CYC = 8,
    parameter int PROT_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [3:0]        prot,
    input  logic              fault,
    output phase_e            phase,
    output logic [3:0]        sel,
    output logic              was_prog,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              wr_en,
    output logic              fill_en,
    output logic [7:0]        fill_val
);
    localparam int MAXC  = max_i(max_i(max_i(PROG_CYC, WIN_CYC), max_i(PRE_CYC, ERASE_CYC)), PROT_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] C_PROG  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] C_WIN   = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] C_PRE   = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] C_ERASE = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] C_PROT  = CNT_W'(PROT_CYC - 1);

    logic [CNT_W-1:0] cnt;
    phase_e           resume_ph;
    logic             bulk;
    op_e              op;
    logic [1:0]       csec;
    logic [3:0]       cbit;
    logic             hit_rst, hit_susp, cnt_zero;

    always_comb begin
        op       = op_e'(cmd_op);
        csec     = cmd_addr[ADDR_W-1 -: 2];
        cbit     = 4'b0001 << csec;
        cnt_zero = (cnt == '0);
        hit_rst  = cmd_valid && (op == OP_RESET);
        hit_susp = cmd_valid && (op == OP_SUSPEND) && !bulk;
        wr_en    = (phase == PH_PROG) && cnt_zero && !fault;
        fill_en  = ((phase == PH_PRE) || (phase == PH_ERASE)) && cnt_zero &&
                   !fault && !hit_rst && !hit_susp;
        fill_val = (phase == PH_PRE) ? 8'h00 : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            resume_ph <= PH_PRE;
            sel       <= '0;
            cnt       <= '0;
            bulk      <= 1'b0;
            was_prog  <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (cmd_valid) begin
                    if (op == OP_PROGRAM && !prot[csec]) begin
                        phase     <= PH_PROG;
                        cnt       <= C_PROG;
                        prog_addr <= cmd_addr;
                        prog_data <= cmd_data;
                        was_prog  <= 1'b1;
                    end else if (op == OP_SECT_ERASE) begin
                        phase    <= PH_WIN;
                        cnt      <= C_WIN;
                        sel      <= cbit;
                        bulk     <= 1'b0;
                        was_prog <= 1'b0;
                    end else if (op == OP_BULK_ERASE && !(&prot)) begin
                        phase    <= PH_PRE;
                        cnt      <= C_PRE;
                        sel      <= ~prot;
                        bulk     <= 1'b1;
                        was_prog <= 1'b0;
                    end
                end
                PH_PROG: begin
                    if (fault)         phase <= PH_FAIL;
                    else if (cnt_zero) phase <= PH_IDLE;
                    else               cnt   <= cnt - 1'b1;
                end
                PH_WIN: begin
                    if (cmd_valid && op == OP_SECT_ERASE) begin
                        sel <= sel | cbit;
                        cnt <= C_WIN;
                    end else if (cmd_valid && op == OP_SUSPEND) begin
                        phase     <= PH_SUSP;
                        resume_ph <= PH_PRE;
                        sel       <= sel & ~prot;
                        cnt       <= C_PRE;
                    end else if (cmd_valid && op != OP_RESUME) begin
                        phase <= PH_IDLE;
                        sel   <= '0;
                    end else if (cnt_zero) begin
                        if ((sel & ~prot) == '0) begin
                            phase <= PH_PROTW;
                            cnt   <= C_PROT;
                            sel   <= '0;
                        end else begin
                            phase <= PH_PRE;
                            cnt   <= C_PRE;
                            sel   <= sel & ~prot;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PROTW: begin
                    if (cnt_zero) phase <= PH_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                PH_PRE, PH_ERASE: begin
                    if (fault) begin
                        phase <= PH_FAIL;
                    end else if (hit_rst) begin
                        phase <= PH_IDLE;
                        sel   <= '0;
                    end else if (hit_susp) begin
                        phase     <= PH_SUSP;
                        resume_ph <= phase;
                    end else if (cnt_zero) begin
                        if (phase == PH_PRE) begin
                            phase <= PH_ERASE;
                            cnt   <= C_ERASE;
                        end else begin
                            phase <= PH_IDLE;
                            sel   <= '0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SUSP: begin
                    if (cmd_valid && op == OP_RESUME) begin
                        phase <= resume_ph;
                    end else if (hit_rst) begin
                        phase <= PH_IDLE;
                        sel   <= '0;
                    end
                end
                PH_FAIL: if (hit_rst) begin
                    phase <= PH_IDLE;
                    sel   <= '0;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fse_rdmux.sv
module fse_rdmux
    import fse_pkg::*;
#(
    parameter logic [7:0] BAD_BYTE = 8'hC3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic [1:0] rd_sec,
    input  phase_e     phase,
    input  logic [3:0] sel,
    input  logic       was_prog,
    input  logic       prog_d7,
    input  logic [7:0] arr_word,
    output logic [7:0] rd_data
);
    logic    tog;
    logic    stat;
    status_t st;
    logic [7:0] val;

    always_comb begin
        stat = is_status_phase(phase);
        st   = '0;
        st.tog = tog;
        val  = arr_word;
        unique case (phase)
            PH_PROG:  st.poll = ~prog_d7;
            PH_PRE, PH_ERASE: st.win_done = 1'b1;
            PH_FAIL: begin
                st.poll     = was_prog ? ~prog_d7 : 1'b0;
                st.err      = 1'b1;
                st.win_done = !was_prog;
            end
            default: ;
        endcase
        if (stat)                                val = st;
        else if (phase == PH_PROTW)              val = 8'h00;
        else if (phase == PH_SUSP && sel[rd_sec]) val = BAD_BYTE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
            tog     <= 1'b0;
        end else if (rd_en) begin
            rd_data <= val;
            if (stat) tog <= ~tog;
        end
    end
endmodule

// File: rtl/fse_engine.sv
module fse_engine #(
    parameter int         ADDR_W    = 6,
    parameter int         PROG_CYC  = 6,
    parameter int         WIN_CYC   = 16,
    parameter int         PRE_CYC   = 5,
    parameter int         ERASE_CYC = 8,
    parameter int         PROT_CYC  = 10,
    parameter logic [7:0] BAD_BYTE  = 8'hC3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [3:0]        sect_prot,
    input  logic              fault,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    fse_pkg::phase_e   phase;
    logic [3:0]        sel;
    logic              was_prog;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic              wr_en, fill_en;
    logic [7:0]        fill_val;
    logic [7:0]        arr_word;

    fse_seq #(
        .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC),
        .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC), .PROT_CYC(PROT_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot(sect_prot), .fault(fault),
        .phase(phase), .sel(sel), .was_prog(was_prog), .prog_addr(prog_addr),
        .prog_data(prog_data), .wr_en(wr_en), .fill_en(fill_en), .fill_val(fill_val)
    );

    fse_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(prog_addr), .wr_data(prog_data),
        .fill_en(fill_en), .fill_mask(sel), .fill_val(fill_val),
        .rd_addr(rd_addr), .rd_word(arr_word)
    );

    fse_rdmux #(.BAD_BYTE(BAD_BYTE)) u_rdmux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sec(rd_addr[ADDR_W-1 -: 2]),
        .phase(phase), .sel(sel), .was_prog(was_prog), .prog_d7(prog_data[7]),
        .arr_word(arr_word), .rd_data(rd_data)
    );
endmodule

// File: rtl/fse_chk.sv
module fse_chk
    import fse_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input phase_e     phase,
    input logic       prog_d7
);
    logic stat_rd, erase_rd;

    always_comb begin
        stat_rd  = rd_en && is_status_phase(phase);
        erase_rd = rd_en && (phase == PH_WIN || phase == PH_PRE || phase == PH_ERASE);
    end

    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (rst) // R2
        (rd_en && phase == PH_PROG) |=> rd_data[7] == ~$past(prog_d7));

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst) // R3
        erase_rd |=> !rd_data[7]);

    AST_TOGGLE_ALT: assert property (@(posedge clk) disable iff (rst) // R4
        (stat_rd && $past(stat_rd)) |=> rd_data[6] != $past(rd_data[6]));

    AST_NO_ERR_RUNNING: assert property (@(posedge clk) disable iff (rst) // R5
        erase_rd |=> !rd_data[5]);

    AST_FAIL_ERR_SET: assert property (@(posedge clk) disable iff (rst) // R5
        (rd_en && phase == PH_FAIL) |=> rd_data[5]);

    AST_WIN_OPEN_DQ3: assert property (@(posedge clk) disable iff (rst) // R6
        (rd_en && phase == PH_WIN) |=> !rd_data[3]);

    AST_ERASING_DQ3: assert property (@(posedge clk) disable iff (rst) // R6
        (rd_en && (phase == PH_PRE || phase == PH_ERASE)) |=> rd_data[3]);

    AST_PROT_WAIT_ZERO: assert property (@(posedge clk) disable iff (rst) // R8
        (rd_en && phase == PH_PROTW) |=> rd_data == 8'h00);
endmodule

bind fse_engine fse_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
    .phase(phase), .prog_d7(prog_data[7])
);

// File: tb/fse_engine_tb_top.sv
module fse_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6, PC = 6, WC = 16, PR = 5, EC = 8, TC = 10;
    localparam logic [7:0] BAD = 8'hC3;
    localparam logic [2:0] O_PROG = 3'd0, O_SERA = 3'd1, O_BULK = 3'd2,
                           O_SUSP = 3'd3, O_RES = 3'd4, O_RST = 3'd5;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, fault = 1'b0, rd_en = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0] cmd_data = '0, rd_data;
    logic [3:0] sect_prot = '0;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;
    logic btog = 1'b0;
    logic [7:0] bmem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    fse_engine #(.ADDR_W(AW), .PROG_CYC(PC), .WIN_CYC(WC), .PRE_CYC(PR),
                 .ERASE_CYC(EC), .PROT_CYC(TC), .BAD_BYTE(BAD)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sect_prot(sect_prot),
        .fault(fault), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [5:0] ad(input int sec, input int off);
        return {2'(sec), 4'(off)};
    endfunction

    function automatic logic [7:0] stat_byte(input logic b7, input logic t,
                                              input logic b5, input logic b3);
        return {b7, t, b5, 1'b0, b3, 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [5:0] a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic chk_arr(input string tag, input logic [5:0] a);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, bmem[a]);
    endtask

    task automatic chk_val(input string tag, input logic [5:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic chk_stat(input string tag, input logic [5:0] a,
                            input logic b7, input logic b5, input logic b3);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, stat_byte(b7, btog, b5, b3));
        btog = ~btog;
    endtask

    task automatic model_fill(input int sec, input logic [7:0] val);
        for (int i = 0; i < 16; i++) bmem[ad(sec, i)] = val;
    endtask

    task automatic pulse_fault();
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] ra;
        logic [7:0] rdv;
        logic [3:0] rp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) bmem[i] = 8'hFF;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk_arr("R1 erased byte", ad(0, 0));
        chk_arr("R1 erased byte top", ad(3, 15));

        // R2, R4: program with status polling and toggle
        do_cmd(O_PROG, ad(1, 3), 8'h5A);
        chk_stat("R2 program status", ad(1, 3), 1'b1, 1'b0, 1'b0);
        chk_stat("R4 toggle second read", ad(2, 0), 1'b1, 1'b0, 1'b0);
        idle(PC + 1);
        bmem[ad(1, 3)] = 8'h5A;
        chk_arr("R2 programmed data", ad(1, 3));

        // R12: commands ignored during program; R2 AND behaviour
        do_cmd(O_PROG, ad(1, 3), 8'h0F);
        do_cmd(O_SERA, ad(1, 0), 8'h00);
        idle(PC + 1);
        bmem[ad(1, 3)] = 8'h0A;
        chk_arr("R12 erase during program ignored", ad(1, 3));

        // R8: protected program ignored
        sect_prot = 4'b0100;
        do_cmd(O_PROG, ad(2, 4), 8'h00);
        chk_arr("R8 protected program ignored", ad(2, 4));
        idle(PC + 1);
        chk_arr("R8 protected byte unchanged", ad(2, 4));

        do_cmd(O_PROG, ad(3, 5), 8'h12); idle(PC + 1); bmem[ad(3, 5)] = 8'h12;
        do_cmd(O_PROG, ad(0, 3), 8'h99); idle(PC + 1); bmem[ad(0, 3)] = 8'h99;

        // R7, R6, R3: batched sector erase with window restart
        do_cmd(O_SERA, ad(1, 0), 8'h00);
        idle(4);
        do_cmd(O_SERA, ad(3, 0), 8'h00);
        idle(WC - 4);
        chk_stat("R7 window restarted", ad(0, 3), 1'b0, 1'b0, 1'b0);
        idle(4);
        chk_stat("R6 erasing dq3 set", ad(0, 3), 1'b0, 1'b0, 1'b1);
        idle(PR + EC + 2);
        model_fill(1, 8'hFF); model_fill(3, 8'hFF);
        chk_arr("R3 sector1 erased", ad(1, 3));
        chk_arr("R3 sector3 erased", ad(3, 5));
        chk_arr("R3 sector0 kept", ad(0, 3));

        // R12: reset during fill-FFh leaves 00h
        do_cmd(O_SERA, ad(0, 0), 8'h00);
        idle(WC + PR + 1);
        do_cmd(O_RST, '0, 8'h00);
        model_fill(0, 8'h00);
        chk_arr("R12 preprogram visible", ad(0, 3));

        // R9, R10: suspend in erase phase, resume
        sect_prot = 4'b0000;
        do_cmd(O_PROG, ad(2, 4), 8'h77); idle(PC + 1); bmem[ad(2, 4)] = 8'h77;
        do_cmd(O_PROG, ad(3, 5), 8'h11); idle(PC + 1); bmem[ad(3, 5)] = 8'h11;
        do_cmd(O_SERA, ad(3, 0), 8'h00);
        idle(WC + 3);
        do_cmd(O_SUSP, '0, 8'h00);
        chk_val("R9 suspended sector invalid", ad(3, 5), BAD);
        chk_arr("R9 other sector valid", ad(2, 4));
        do_cmd(O_PROG, ad(2, 5), 8'h00);
        chk_arr("R10 program while suspended ignored", ad(2, 5));
        do_cmd(O_RES, '0, 8'h00);
        chk_stat("R10 resumed erase", ad(2, 4), 1'b0, 1'b0, 1'b1);
        idle(PR + EC + 2);
        model_fill(3, 8'hFF);
        chk_arr("R10 resumed erase completes", ad(3, 5));

        // R10: suspend in window then reset abandons
        do_cmd(O_SERA, ad(2, 0), 8'h00);
        idle(3);
        do_cmd(O_SUSP, '0, 8'h00);
        chk_val("R9 window suspend invalid", ad(2, 4), BAD);
        do_cmd(O_RST, '0, 8'h00);
        chk_arr("R10 reset abandons erase", ad(2, 4));

        // R11: other command in window aborts
        do_cmd(O_SERA, ad(2, 0), 8'h00);
        idle(2);
        do_cmd(O_PROG, ad(1, 3), 8'h00);
        chk_arr("R11 window aborted", ad(2, 4));
        idle(PC + 2);
        chk_arr("R11 aborting program not run", ad(1, 3));

        // R8: all selected protected
        sect_prot = 4'b0100;
        do_cmd(O_SERA, ad(2, 0), 8'h00);
        idle(WC);
        chk_val("R8 all protected reports 00h", ad(2, 4), 8'h00);
        idle(TC + 1);
        chk_arr("R8 protected sector kept", ad(2, 4));

        sect_prot = 4'b1111;
        do_cmd(O_BULK, '0, 8'h00);
        chk_arr("R8 bulk all protected ignored", ad(2, 4));

        // R8, R11: bulk erase skips protected, ignores suspend
        sect_prot = 4'b0100;
        do_cmd(O_BULK, '0, 8'h00);
        chk_stat("R8 bulk running", ad(0, 0), 1'b0, 1'b0, 1'b1);
        do_cmd(O_SUSP, '0, 8'h00);
        chk_stat("R11 bulk suspend ignored", ad(0, 0), 1'b0, 1'b0, 1'b1);
        idle(PR + EC + 2);
        model_fill(0, 8'hFF); model_fill(1, 8'hFF); model_fill(3, 8'hFF);
        chk_arr("R8 bulk erased sector3", ad(3, 5));
        chk_arr("R8 bulk erased sector0", ad(0, 3));
        chk_arr("R8 bulk skipped sector2", ad(2, 4));

        // R5: fault during program
        sect_prot = 4'b0000;
        do_cmd(O_PROG, ad(0, 6), 8'h40);
        idle(1);
        pulse_fault();
        chk_stat("R5 program fault", ad(0, 6), 1'b1, 1'b1, 1'b0);
        idle(20);
        chk_stat("R5 error held", ad(0, 6), 1'b1, 1'b1, 1'b0);
        do_cmd(O_RST, '0, 8'h00);
        chk_arr("R5 reset returns array", ad(0, 6));

        // R5: fault during erase phase
        do_cmd(O_SERA, ad(1, 0), 8'h00);
        idle(WC + 2);
        pulse_fault();
        chk_stat("R5 erase fault", ad(0, 0), 1'b0, 1'b1, 1'b1);
        do_cmd(O_RST, '0, 8'h00);
        chk_arr("R5 erase fault no change", ad(1, 3));

        // R2, R8: seeded random programs under random protection
        for (int k = 0; k < 40; k++) begin
            rp = 4'($urandom_range(0, 15));
            ra = 6'($urandom_range(0, 63));
            rdv = 8'($urandom_range(0, 255));
            sect_prot = rp;
            do_cmd(O_PROG, ra, rdv);
            if (!rp[ra[5:4]]) bmem[ra] = bmem[ra] & rdv;
            idle(PC + 1);
            chk_arr("R2 random program", ra);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule